// File: doc/BRIEF.md
# Watchdog and Interval Timer with Write-Once Mode Register

This block is a timer that is either a periodic interval source or a watchdog. It is controlled by an 8-bit mode register that a CPU writes through a strobe interface. The interface takes either a whole-byte write or a write of one addressed bit. A free-running prescaler counts system clocks, and a 3-bit period select picks which prescaler tap advances an 8-bit main counter. When the main counter rolls over, the block signals one of three events, depending on the mode bits. The first is a one-cycle maskable interrupt request. The second is a one-cycle non-maskable interrupt request. The third is a reset request that stays high until the block itself is reset.

The run bit and the two mode-select bits can be set to one by software, but only the block reset clears them. Software services the watchdog by writing the run bit to one again, which clears the main counter. The prescaler is not touched by that write. As a result, the first period after a service write can be up to one tick of the main counter shorter than the nominal period.

Top module: `wdt_guard`

## Requirements
- R1: After reset the mode register reads 8'h00, all three event outputs are low, and while the run bit (bit 7) is 0 no event is raised.
- R2: Only bits 7, 4 and 3 of the mode register are implemented; every other bit reads 0 whatever is written to it.
- R3: Bits 7, 4 and 3 are sticky: a byte write or bit write of 0 to a bit already set leaves it at 1; only reset clears them.
- R4: A bit write (bit index 0..7, value 0/1) sets only the addressed bit and leaves all other bits unchanged.
- R5: Writing 1 to bit 7, whether by a byte write or a bit write, clears the main counter in that cycle and leaves the prescaler running. If that write is sampled at clock edge E, the first overflow occurs at edge (floor(E/P)+1)*P + 255*P, where P is the tick period and edges are counted from reset release.
- R6: The main counter advances once every P = 2^(period_sel+1) clocks, on edges whose number is a multiple of P, and overflows after 256 such ticks.
- R7: With bit 4 = 0 (bit 3 ignored), each overflow gives a one-cycle pulse on irq_mask in the cycle after the overflow edge, repeating every 256*P clocks.
- R8: With bit 4 = 1 and bit 3 = 0, each overflow gives a one-cycle pulse on irq_nmi instead; at most one event output is high at a time.
- R9: With bits 4 and 3 both 1, an overflow raises rst_req, which stays high until rst_n is asserted.
- R10: A bit-7 write sampled on the same edge as an overflow wins: no event is raised and the counter restarts from 0.
- R11: A write that does not set bit 7 to 1 does not restart the counter; a mode change made that way applies to the next overflow on the unchanged schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_we | input | 1 | Whole-byte write strobe |
| byte_data | input | 8 | Data for a whole-byte write |
| bit_we | input | 1 | Single-bit write strobe |
| bit_idx | input | 3 | Index of the bit written by a bit write |
| bit_val | input | 1 | Value of the bit written by a bit write |
| period_sel | input | 3 | Prescaler tap select; tick period is 2^(period_sel+1) clocks |
| mode_rd | output | 8 | Current mode register contents |
| irq_mask | output | 1 | Maskable interrupt request pulse |
| irq_nmi | output | 1 | Non-maskable interrupt request pulse |
| rst_req | output | 1 | Held reset request |

## Verification
A service write and a counter overflow can land on the same clock edge, and the two disagree about what the counter should do. The bench places a bit write of the run bit so that it is sampled on the exact edge where overflow is due, computed from the tick period. It then expects that no event appears and that the next overflow follows the restart schedule. The scoreboard also provokes a mode change between overflows of a running timer and judges that the change alters the kind of event but not its timing.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int MODE_W   = 8;
    localparam int RUN_POS  = 7;
    localparam int SELA_POS = 4;
    localparam int SELB_POS = 3;
    localparam logic [MODE_W-1:0] MODE_IMPL =
        (MODE_W'(1) << RUN_POS) | (MODE_W'(1) << SELA_POS) | (MODE_W'(1) << SELB_POS);

    typedef enum logic [1:0] {
        EV_MASKABLE = 2'd0,
        EV_NMI      = 2'd1,
        EV_RESET    = 2'd2
    } wdt_event_e;
endpackage

// File: rtl/wdt_mode_reg.sv
module wdt_mode_reg
    import wdt_pkg::*;
#(
    parameter int REG_W = MODE_W,
    localparam int IDX_W = $clog2(REG_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_we,
    input  logic [REG_W-1:0] byte_data,
    input  logic             bit_we,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_val,
    output logic [REG_W-1:0] mode_q,
    output logic             restart
);
    typedef struct packed {
        logic [REG_W-1:0] mode;
    } state_t;

    state_t st_d, st_q;
    logic [REG_W-1:0] set_byte;
    logic [REG_W-1:0] set_bit;

    always_comb begin
        set_byte = byte_we ? (byte_data & REG_W'(MODE_IMPL)) : '0;
        set_bit  = (bit_we && bit_val) ? ((REG_W'(1) << bit_idx) & REG_W'(MODE_IMPL)) : '0;
        // set-only update: implemented bits stick at one until reset
        st_d.mode = st_q.mode | set_byte | set_bit;
        restart   = set_byte[RUN_POS] | set_bit[RUN_POS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q = st_q.mode;
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int SEL_W = 3,
    parameter int PRE_W = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] period_sel,
    output logic             tick
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } state_t;

    state_t st_d, st_q;
    logic [PRE_W-1:0] tap_mask;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            tap_mask[i] = (i <= int'(period_sel));
        end
        tick     = ((st_q.pre & tap_mask) == tap_mask);
        st_d.pre = st_q.pre + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel_a,
    input  logic sel_b,
    input  logic tick,
    input  logic restart,
    output logic irq_mask,
    output logic irq_nmi,
    output logic rst_req
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             nmi;
        logic             rreq;
    } state_t;

    state_t st_d, st_q;
    logic   ovf;

    always_comb begin
        st_d = st_q;
        ovf  = run && tick && (st_q.cnt == CNT_TOP) && !restart;
        if (restart) begin
            st_d.cnt = '0;
        end else if (run && tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        st_d.irq  = ovf && !sel_a;
        st_d.nmi  = ovf && sel_a && !sel_b;
        st_d.rreq = st_q.rreq || (ovf && sel_a && sel_b);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_mask = st_q.irq;
    assign irq_nmi  = st_q.nmi;
    assign rst_req  = st_q.rreq;
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int PRE_W = 1 << SEL_W,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_we,
    input  logic [MODE_W-1:0] byte_data,
    input  logic              bit_we,
    input  logic [2:0]        bit_idx,
    input  logic              bit_val,
    input  logic [SEL_W-1:0]  period_sel,
    output logic [MODE_W-1:0] mode_rd,
    output logic              irq_mask,
    output logic              irq_nmi,
    output logic              rst_req
);
    logic restart;
    logic tick;

    wdt_mode_reg #(.REG_W(MODE_W)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_we   (byte_we),
        .byte_data (byte_data),
        .bit_we    (bit_we),
        .bit_idx   (bit_idx),
        .bit_val   (bit_val),
        .mode_q    (mode_rd),
        .restart   (restart)
    );

    wdt_prescaler #(.SEL_W(SEL_W), .PRE_W(PRE_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_sel (period_sel),
        .tick       (tick)
    );

    wdt_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (mode_rd[RUN_POS]),
        .sel_a    (mode_rd[SELA_POS]),
        .sel_b    (mode_rd[SELB_POS]),
        .tick     (tick),
        .restart  (restart),
        .irq_mask (irq_mask),
        .irq_nmi  (irq_nmi),
        .rst_req  (rst_req)
    );
endmodule

// File: rtl/wdt_checks.sv
module wdt_checks
    import wdt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode_rd,
    input logic              irq_mask,
    input logic              irq_nmi,
    input logic              rst_req
);
    p_unimpl_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd & ~MODE_IMPL) == '0);

    p_run_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rd[RUN_POS] |=> mode_rd[RUN_POS]);

    p_sela_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rd[SELA_POS] |=> mode_rd[SELA_POS]);

    p_selb_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rd[SELB_POS] |=> mode_rd[SELB_POS]);

    p_stopped_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_rd[RUN_POS] |=> !(irq_mask || irq_nmi || rst_req));

    p_mask_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |=> !irq_mask);

    p_nmi_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nmi |=> !irq_nmi);

    p_nmi_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nmi |-> ($past(mode_rd[SELA_POS]) && !$past(mode_rd[SELB_POS])));

    p_one_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_mask, irq_nmi, rst_req}));

    p_rreq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);
endmodule

bind wdt_guard wdt_checks u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_rd  (mode_rd),
    .irq_mask (irq_mask),
    .irq_nmi  (irq_nmi),
    .rst_req  (rst_req)
);

// File: tb/tb_wdt_guard.sv
`timescale 1ns/1ps
module tb_wdt_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_we = 1'b0;
    logic [7:0] byte_data = '0;
    logic       bit_we = 1'b0;
    logic [2:0] bit_idx = '0;
    logic       bit_val = 1'b0;
    logic [2:0] period_sel = '0;
    logic [7:0] mode_rd;
    logic       irq_mask, irq_nmi, rst_req;

    always #2.5 clk = ~clk;

    wdt_guard dut (
        .clk(clk), .rst_n(rst_n), .byte_we(byte_we), .byte_data(byte_data),
        .bit_we(bit_we), .bit_idx(bit_idx), .bit_val(bit_val),
        .period_sel(period_sel), .mode_rd(mode_rd), .irq_mask(irq_mask),
        .irq_nmi(irq_nmi), .rst_req(rst_req)
    );

    typedef struct {
        int    at;
        int    kind;
        string tag;
    } exp_t;

    exp_t  sb[$];
    int    edge_n = 0;
    int    checks = 0;
    int    errors = 0;
    int    unexp = 0;
    int    rr_bad = 0;
    int    rr_from = 0;
    int    last_e = 0;
    bit    done = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_n <= 0;
        else        edge_n <= edge_n + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, expv, edge_n);
        end
    endtask

    // monitor: pops expected events and compares them with the outputs
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sb.size() > 0 && sb[0].at == edge_n) begin
                exp_t e;
                logic [2:0] got, want;
                e    = sb.pop_front();
                got  = {rst_req, irq_nmi, irq_mask};
                want = (e.kind == 0) ? 3'b001 : (e.kind == 1) ? 3'b010 : 3'b100;
                chk(got === want, e.tag, int'(got), int'(want));
            end else if (irq_mask || irq_nmi) begin
                unexp++;
            end
            if (rst_req !== (rr_from > 0 && edge_n >= rr_from)) rr_bad++;
        end
    end

    function automatic int first_ov(input int e, input int p);
        return (e / p + 1) * p + 255 * p;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sb.delete();
        rr_from = 0;
        unexp = 0;
        rr_bad = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_byte(input logic [7:0] d);
        @(negedge clk);
        byte_we = 1'b1;
        byte_data = d;
        last_e = edge_n + 1;
        @(negedge clk);
        byte_we = 1'b0;
    endtask

    task automatic wr_bit(input logic [2:0] idx, input logic v);
        @(negedge clk);
        bit_we = 1'b1;
        bit_idx = idx;
        bit_val = v;
        last_e = edge_n + 1;
        @(negedge clk);
        bit_we = 1'b0;
    endtask

    task automatic wait_until(input int n);
        while (edge_n < n) @(negedge clk);
    endtask

    task automatic push(input int at, input int kind, input string tag);
        exp_t e;
        e.at = at;
        e.kind = kind;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic phase_end(input string tag);
        chk(unexp == 0, {tag, " unexpected pulses"}, unexp, 0);
        chk(rr_bad == 0, {tag, " rst_req level"}, rr_bad, 0);
        chk(sb.size() == 0, {tag, " missing events"}, sb.size(), 0);
    endtask

    initial begin
        int m1;
        int m2;
        do_reset();
        // R1: reset state, stopped counter stays quiet
        @(negedge clk);
        chk(mode_rd === 8'h00, "R1 mode after reset", int'(mode_rd), 0);
        chk({irq_mask, irq_nmi, rst_req} === 3'b000, "R1 outputs after reset",
            int'({irq_mask, irq_nmi, rst_req}), 0);
        wait_until(1200);
        phase_end("R1 stopped");

        // R2/R4/R3: register behaviour without starting the timer
        wr_byte(8'h67);
        chk(mode_rd === 8'h00, "R2 unimplemented byte bits", int'(mode_rd), 0);
        wr_bit(3'd5, 1'b1);
        chk(mode_rd === 8'h00, "R2 unimplemented bit write", int'(mode_rd), 0);
        wr_bit(3'd3, 1'b1);
        chk(mode_rd === 8'h08, "R4 bit write bit 3", int'(mode_rd), 8'h08);
        wr_bit(3'd4, 1'b1);
        chk(mode_rd === 8'h18, "R4 bit write bit 4", int'(mode_rd), 8'h18);
        wr_byte(8'h00);
        chk(mode_rd === 8'h18, "R3 byte zero keeps bits", int'(mode_rd), 8'h18);
        wr_bit(3'd4, 1'b0);
        chk(mode_rd === 8'h18, "R3 bit zero keeps bit 4", int'(mode_rd), 8'h18);

        // R7/R11/R3: interval mode, then mode change without restart
        do_reset();
        period_sel = 3'd0;
        wr_byte(8'h80);
        m1 = first_ov(last_e, 2);
        push(m1, 0, "R7 first maskable");
        wait_until(m1 + 20);
        wr_bit(3'd4, 1'b1);
        push(m1 + 512, 1, "R11 nmi on old schedule");
        push(m1 + 1024, 1, "R8 nmi repeat");
        wr_byte(8'h00);
        chk(mode_rd === 8'h90, "R3 run stays set", int'(mode_rd), 8'h90);
        wait_until(m1 + 1100);
        phase_end("R11 interval");

        // R5/R6/R8: service restart keeps prescaler phase, P=8
        do_reset();
        period_sel = 3'd2;
        wait_until(98);
        wr_byte(8'h90);
        wait_until(999);
        wr_bit(3'd7, 1'b1);
        m2 = first_ov(last_e, 8);
        chk(m2 - last_e == 2047, "R5 short first period", m2 - last_e, 2047);
        push(m2, 1, "R5 nmi after restart");
        push(m2 + 2048, 1, "R6 period 256 ticks");
        wait_until(m2 + 2100);
        phase_end("R5 restart");

        // R10/R7: restart on the overflow edge, bit 3 ignored in interval mode
        do_reset();
        period_sel = 3'd0;
        wr_byte(8'h88);
        m1 = first_ov(last_e, 2);
        wait_until(m1 - 2);
        wr_bit(3'd7, 1'b1);
        chk(last_e == m1, "R10 write on overflow edge", last_e, m1);
        m2 = first_ov(last_e, 2);
        push(m2, 0, "R10 event after collision");
        wait_until(m2 + 10);
        phase_end("R10 collision");

        // R9: reset request held until reset
        do_reset();
        period_sel = 3'd0;
        wr_byte(8'h98);
        m1 = first_ov(last_e, 2);
        push(m1, 2, "R9 reset request");
        rr_from = m1;
        wait_until(m1 + 700);
        phase_end("R9 held");
        do_reset();
        @(negedge clk);
        chk(rst_req === 1'b0, "R9 cleared by reset", int'(rst_req), 0);
        chk(mode_rd === 8'h00, "R1 mode cleared by reset", int'(mode_rd), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule